// File: doc/BRIEF.md
# Peripheral Register Bit-Field Access Unit

This unit lets a small sequencer read or modify a contiguous range of bits inside a 32-bit peripheral register. Registers are selected by a word address. A command names the register, an upper and a lower bit position, and an 8-bit immediate. The sequencer starts a command with a one-cycle strobe and then waits for the completion pulse.

A read fetches the register over a simple synchronous register bus. It shifts the selected range down to bit 0 and returns it on a 16-bit write port into accumulator register R0, with zeros above the field.

A write performs read-modify-write. It fetches the register and replaces only the selected range with the immediate, which is zero-extended or truncated to the field width. It then writes the whole word back, so every other bit of the register is left unchanged. Both directions take a fixed number of cycles. A read takes 4 cycles and a write takes 8.

Top module: `pfa_unit`

## Requirements
- R1: After reset, `busy`, `done`, `bus_req`, `bus_we` and `r0_we` are all low.
- R2: A command is accepted on a clock edge where `cmd_valid` is high and `busy` is low, and `busy` is high from the next cycle. Any `cmd_valid` seen while `busy` is high is ignored: no second bus access is made and no register changes.
- R3: In the first busy cycle the unit issues exactly one bus read (`bus_req`=1, `bus_we`=0) to the command address. Read data is taken from `bus_rdata` in the following cycle.
- R4: A read command lasts 4 busy cycles. In the 4th cycle, `r0_we` is high and `r0_wdata` holds register bits hi..lo shifted to bit 0, with zeros above them. For example, bits 7:4 of 0x...A5 give 0x000A.
- R5: When a read field is wider than 16 bits, `r0_wdata` holds its lowest 16 bits, which are register bits lo..lo+15.
- R6: A write command lasts 8 busy cycles. In the 8th cycle it issues one bus write (`bus_req`=1, `bus_we`=1) to the command address. After that write, register bits hi..lo hold the immediate.
- R7: A write leaves every register bit outside hi..lo at the value it had before the command.
- R8: Immediate bits at positions at or above the field width are discarded. Field bits above immediate bit 7 are written as zero.
- R9: When hi < lo the field is empty. A read returns 0, and a write puts back the register word unchanged.
- R10: `done` is high for exactly the last busy cycle, and `busy` is low in the cycle after it. `r0_we` is never high during a write command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe |
| cmd_write | input | 1 | 1 = field write, 0 = field read |
| cmd_addr | input | ADDR_W | Register word address |
| cmd_hi | input | 5 | Upper bit position of the field |
| cmd_lo | input | 5 | Lower bit position of the field |
| cmd_imm | input | IMM_W | Immediate for a write |
| busy | output | 1 | Command in progress |
| done | output | 1 | Final cycle of a command |
| bus_req | output | 1 | Register bus access request |
| bus_we | output | 1 | Register bus write enable |
| bus_addr | output | ADDR_W | Register bus word address |
| bus_wdata | output | 32 | Register bus write data |
| bus_rdata | input | 32 | Register bus read data, valid the cycle after a read request |
| r0_we | output | 1 | R0 write enable |
| r0_wdata | output | RES_W | R0 write data |

## Verification
The bench builds the unit with a 6-bit address, the 16-bit result, the 8-bit immediate and the budgets of 4 and 8 cycles. These are the values for which R4 and R6 fix the cycle counts. With this result width, a full 32-bit field exposes the truncation of R5. With this immediate width, fields of 3 and 16 bits reach both sides of R8, truncation and zero-extension. The bus model in the bench holds sixteen registers, enough to issue an ignored command to a second address while a read is in flight.

// File: rtl/pfa_pkg.sv
package pfa_pkg;
  localparam int WORD_W = 32;
  localparam int POS_W  = $clog2(WORD_W);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [POS_W-1:0]  pos_t;
  typedef logic [POS_W:0]    span_t;
  typedef logic [WORD_W:0]   wide_t;

  // Field mask: ((1 << (hi-lo+1)) - 1) << lo, empty when hi < lo.
  function automatic word_t fld_mask(input pos_t hi, input pos_t lo);
    span_t span;
    wide_t ones;
    if (hi < lo) return '0;
    span = span_t'(hi) - span_t'(lo) + span_t'(1);
    ones = (wide_t'(1) << span) - wide_t'(1);
    return ones[WORD_W-1:0] << lo;
  endfunction

  // Selected bits moved down to bit 0.
  function automatic word_t fld_get(input word_t w, input word_t m, input pos_t lo);
    return (w & m) >> lo;
  endfunction

  // Replace the masked bits of w by val placed at lo; val bits past the field drop out.
  function automatic word_t fld_put(input word_t w, input word_t m, input pos_t lo,
                                    input word_t val);
    return (w & ~m) | ((val << lo) & m);
  endfunction
endpackage

// File: rtl/pfa_seq.sv
module pfa_seq #(
  parameter int RD_STEPS = 4,
  parameter int WR_STEPS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic is_wr,
  output logic busy,
  output logic op_wr,
  output logic st_rd_req,
  output logic st_cap,
  output logic st_merge,
  output logic st_last
);
  localparam int STEP_W = $clog2(WR_STEPS + 1);
  localparam logic [STEP_W-1:0] RD_LAST = STEP_W'(RD_STEPS - 1);
  localparam logic [STEP_W-1:0] WR_LAST = STEP_W'(WR_STEPS - 1);

  logic [STEP_W-1:0] step_q;
  logic              busy_q;
  logic              wr_q;
  logic [STEP_W-1:0] last_idx;

  assign last_idx = wr_q ? WR_LAST : RD_LAST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
      step_q <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        wr_q   <= is_wr;
        step_q <= '0;
      end
    end else if (step_q == last_idx) begin
      busy_q <= 1'b0;
    end else begin
      step_q <= step_q + STEP_W'(1);
    end
  end

  assign busy      = busy_q;
  assign op_wr     = wr_q;
  assign st_rd_req = busy_q && (step_q == '0);
  assign st_cap    = busy_q && (step_q == STEP_W'(1));
  assign st_merge  = busy_q && wr_q && (step_q == STEP_W'(2));
  assign st_last   = busy_q && (step_q == last_idx);

  // R10: completion is a single-cycle event followed by idle
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    st_last |=> !st_last);
  a_r10_idle_after: assert property (@(posedge clk) disable iff (!rst_n)
    st_last |=> !busy_q);
  // R2: an operation keeps its direction while busy
  a_r2_dir_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !st_last |=> $stable(wr_q));
  // R6: merge precedes the final step of a write
  a_r6_merge_before_last: assert property (@(posedge clk) disable iff (!rst_n)
    st_merge |-> !st_last);
endmodule

// File: rtl/pfa_field.sv
module pfa_field
  import pfa_pkg::*;
#(
  parameter int RES_W = 16,
  parameter int IMM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic             merge_en,
  input  pos_t             hi,
  input  pos_t             lo,
  input  logic [IMM_W-1:0] imm,
  input  word_t            rdata,
  output word_t            wr_word,
  output logic [RES_W-1:0] rd_field
);
  word_t cap_q;
  word_t mrg_q;
  word_t mask;
  word_t got;

  assign mask = fld_mask(hi, lo);
  assign got  = fld_get(cap_q, mask, lo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
      mrg_q <= '0;
    end else begin
      if (cap_en)   cap_q <= rdata;
      if (merge_en) mrg_q <= fld_put(cap_q, mask, lo, word_t'(imm));
    end
  end

  assign wr_word  = mrg_q;
  assign rd_field = got[RES_W-1:0];

  // R7: the merged word agrees with the captured word outside the field
  a_r7_keep_outside: assert property (@(posedge clk) disable iff (!rst_n)
    merge_en |=> ((mrg_q ^ cap_q) & ~mask) == '0);
  // R9: an empty field merges to the captured word unchanged
  a_r9_empty_merge: assert property (@(posedge clk) disable iff (!rst_n)
    merge_en && (hi < lo) |=> mrg_q == cap_q);
endmodule

// File: rtl/pfa_unit.sv
module pfa_unit
  import pfa_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int RES_W    = 16,
  parameter int IMM_W    = 8,
  parameter int RD_STEPS = 4,
  parameter int WR_STEPS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [POS_W-1:0]  cmd_hi,
  input  logic [POS_W-1:0]  cmd_lo,
  input  logic [IMM_W-1:0]  cmd_imm,
  output logic              busy,
  output logic              done,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [WORD_W-1:0] bus_wdata,
  input  logic [WORD_W-1:0] bus_rdata,
  output logic              r0_we,
  output logic [RES_W-1:0]  r0_wdata
);
  logic              accept;
  logic              op_wr;
  logic              st_rd_req, st_cap, st_merge, st_last;
  logic [ADDR_W-1:0] addr_q;
  pos_t              hi_q, lo_q;
  logic [IMM_W-1:0]  imm_q;
  word_t             wr_word;
  logic [RES_W-1:0]  rd_field;

  assign accept = cmd_valid && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
      imm_q  <= '0;
    end else if (accept) begin
      addr_q <= cmd_addr;
      hi_q   <= cmd_hi;
      lo_q   <= cmd_lo;
      imm_q  <= cmd_imm;
    end
  end

  pfa_seq #(.RD_STEPS(RD_STEPS), .WR_STEPS(WR_STEPS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .is_wr(cmd_write),
    .busy(busy), .op_wr(op_wr), .st_rd_req(st_rd_req), .st_cap(st_cap),
    .st_merge(st_merge), .st_last(st_last)
  );

  pfa_field #(.RES_W(RES_W), .IMM_W(IMM_W)) u_field (
    .clk(clk), .rst_n(rst_n), .cap_en(st_cap), .merge_en(st_merge),
    .hi(hi_q), .lo(lo_q), .imm(imm_q), .rdata(bus_rdata),
    .wr_word(wr_word), .rd_field(rd_field)
  );

  assign bus_we    = st_last && op_wr;
  assign bus_req   = st_rd_req || bus_we;
  assign bus_addr  = addr_q;
  assign bus_wdata = wr_word;
  assign done      = st_last;
  assign r0_we     = st_last && !op_wr;
  assign r0_wdata  = rd_field;

  // R1: an idle unit drives no bus, completion or R0 activity
  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_req && !done && !r0_we);
  // R3: the first busy cycle is a bus read
  a_r3_read_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> bus_req && !bus_we);
  // R2: the address stays fixed for the whole command
  a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> $stable(bus_addr));
  // R10: R0 is written only at completion of a command that does not write the bus
  a_r10_r0_only_read: assert property (@(posedge clk) disable iff (!rst_n)
    r0_we |-> done && !bus_req);
  // R6: a bus write only happens in the completion cycle
  a_r6_write_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> done && bus_req);
endmodule

// File: tb/pfa_unit_bench.sv
module pfa_unit_bench;
  localparam int ADDR_W = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_valid = 1'b0;
  logic              cmd_write = 1'b0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [4:0]        cmd_hi = '0;
  logic [4:0]        cmd_lo = '0;
  logic [7:0]        cmd_imm = '0;
  logic              busy, done, bus_req, bus_we, r0_we;
  logic [ADDR_W-1:0] bus_addr;
  logic [31:0]       bus_wdata;
  logic [31:0]       bus_rdata = '0;
  logic [15:0]       r0_wdata;

  logic [31:0] mem [16];
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pfa_unit #(.ADDR_W(ADDR_W), .RES_W(16), .IMM_W(8), .RD_STEPS(4), .WR_STEPS(8)) u_pfa_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo), .cmd_imm(cmd_imm),
    .busy(busy), .done(done), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .r0_we(r0_we), .r0_wdata(r0_wdata)
  );

  always @(posedge clk) begin
    if (bus_req) begin
      if (bus_we) mem[bus_addr[3:0]] <= bus_wdata;
      else        bus_rdata <= mem[bus_addr[3:0]];
    end
  end

  function automatic logic [15:0] exp_get(logic [31:0] w, int h, int l);
    logic [15:0] r = '0;
    for (int j = 0; j < 16; j++)
      if (l + j <= h && l + j < 32) r[j] = w[l + j];
    return r;
  endfunction

  function automatic logic [31:0] exp_put(logic [31:0] w, int h, int l, logic [7:0] im);
    logic [31:0] r = w;
    for (int i = 0; i < 32; i++)
      if (i >= l && i <= h) r[i] = (i - l < 8) ? im[i - l] : 1'b0;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  int          r_cyc, r_done, r_rd, r_rdcnt, r_wr, r_wrcnt, r_r0cnt;
  logic [15:0] r_r0;
  logic [ADDR_W-1:0] r_addr;

  task automatic run_cmd(input bit wr, input int a, input int h, input int l,
                         input logic [7:0] im, input bit intrude);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_addr = ADDR_W'(a);
    cmd_hi = 5'(h); cmd_lo = 5'(l); cmd_imm = im;
    r_cyc = 0; r_done = 0; r_rd = 0; r_rdcnt = 0; r_wr = 0; r_wrcnt = 0;
    r_r0cnt = 0; r_r0 = '0; r_addr = '0;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (busy && r_cyc < 100) begin
      r_cyc++;
      if (bus_req && !bus_we) begin r_rdcnt++; r_rd = r_cyc; r_addr = bus_addr; end
      if (bus_req && bus_we) begin r_wrcnt++; r_wr = r_cyc; end
      if (done) r_done = r_cyc;
      if (r0_we) begin r_r0cnt++; r_r0 = r0_wdata; end
      if (intrude && r_cyc == 2) begin
        cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = ADDR_W'(9);
        cmd_hi = 5'd31; cmd_lo = 5'd0; cmd_imm = 8'h77;
      end else begin
        cmd_valid = 1'b0;
      end
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    if (r_cyc >= 100) chk(1'b0, "R10 watchdog", 32'(r_cyc), 32'd0);
  endtask

  task automatic t_reset();
    chk(!busy && !done, "R1 busy/done", {30'd0, busy, done}, 32'd0);
    chk(!bus_req && !bus_we && !r0_we, "R1 bus/r0", {29'd0, bus_req, bus_we, r0_we}, 32'd0);
  endtask

  task automatic t_read(input int a, input int h, input int l, input string req);
    logic [15:0] e;
    e = exp_get(mem[a], h, l);
    run_cmd(1'b0, a, h, l, 8'h00, 1'b0);
    chk(r_r0 == e && r_r0cnt == 1, req, 32'(r_r0), 32'(e));
    chk(r_cyc == 4 && r_done == 4, "R4 read span/done", 32'(r_cyc), 32'd4);
    chk(r_rdcnt == 1 && r_rd == 1 && r_addr == ADDR_W'(a), "R3 read request",
        32'(r_rd), 32'd1);
    chk(r_wrcnt == 0 && !done, "R10 no write on read", 32'(r_wrcnt), 32'd0);
  endtask

  task automatic t_write(input int a, input int h, input int l, input logic [7:0] im,
                         input string req);
    logic [31:0] e;
    e = exp_put(mem[a], h, l, im);
    run_cmd(1'b1, a, h, l, im, 1'b0);
    chk(mem[a] == e, req, mem[a], e);
    chk(r_cyc == 8 && r_done == 8 && r_wr == 8 && r_wrcnt == 1, "R6 write span",
        32'(r_wr), 32'd8);
    chk(r_rdcnt == 1 && r_rd == 1, "R3 read before write", 32'(r_rd), 32'd1);
    chk(r_r0cnt == 0, "R10 r0 idle on write", 32'(r_r0cnt), 32'd0);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] keep;
    keep = mem[9];
    run_cmd(1'b0, 1, 15, 8, 8'h00, 1'b1);
    chk(r_r0 == exp_get(mem[1], 15, 8) && r_cyc == 4, "R2 read unaffected",
        32'(r_r0), 32'(exp_get(mem[1], 15, 8)));
    chk(r_rdcnt == 1 && r_wrcnt == 0, "R2 single access", 32'(r_rdcnt + r_wrcnt), 32'd1);
    repeat (3) @(negedge clk);
    chk(!busy && mem[9] == keep, "R2 ignored command", mem[9], keep);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'h1111_0000 * 32'(i) + 32'(i);
    mem[1] = 32'h1234_56A5;
    mem[2] = 32'hDEAD_BEEF;
    mem[3] = 32'hFFFF_0000;
    mem[4] = 32'h0000_0000;
    mem[5] = 32'hA5A5_A5A5;
    mem[9] = 32'h9999_1234;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_read(1, 7, 4, "R4 bits 7:4");
    t_read(1, 15, 0, "R4 bits 15:0");
    t_read(1, 31, 31, "R4 single top bit");
    t_read(2, 31, 0, "R5 full word truncated");
    t_read(2, 27, 8, "R5 wide mid field");
    t_read(5, 3, 9, "R9 empty read");
    t_write(3, 11, 4, 8'h5C, "R7 write 11:4 keeps others");
    t_write(4, 2, 0, 8'hFF, "R8 narrow field drops imm bits");
    t_write(3, 23, 8, 8'h81, "R8 wide field zero-extends");
    t_write(5, 3, 9, 8'hFF, "R9 empty write unchanged");
    t_write(4, 31, 24, 8'hC3, "R6 top byte");
    t_busy_ignore();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL R10 watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule